// File: doc/BRIEF.md
# Translation Request Coalescing Queue

This block sits between several requesters that need virtual-to-physical page translations and a single downstream translation port. Each accepted request carries a virtual page number, a read/write mode and a request count. Requests that arrive within the same time window, for the same page and with the same mode, are folded into one stored entry whose count is the sum of theirs. The downstream side therefore sees one lookup for a group of requests.

Stored entries are offered downstream one per cycle, oldest first. An entry is skipped while a translation for its page is still in flight, and nothing is offered while the outstanding-translation table is full. A refused offer leaves the entry in place. A response naming a page releases that page's outstanding slot. A mode input turns merging off, so that every request becomes its own entry.

Top module: `coal_top`

## Requirements
- R1: A request merges into a stored entry when the page number, the mode (`req_write`) and the arrival window all match and `cfg_no_merge` is 0. The entry's count becomes the sum of both counts.
- R2: A request whose page number or mode differs from every stored entry of its window is appended as a new entry at the tail.
- R3: The window index advances every `WIN` cycles after reset. A request never merges into an entry stored under a different window index.
- R4: While `cfg_no_merge` is 1, every accepted request is appended as its own entry.
- R5: A merged count saturates at 2^CNT_W-1 (15 with defaults).
- R6: `dn_valid`, `dn_vpn`, `dn_write` and `dn_cnt` present the lowest-positioned eligible entry in insertion order. At most one entry is sent per cycle, no earlier than the cycle after it was accepted. A sent entry (`dn_valid` and `dn_ready` high together) leaves the queue.
- R7: An entry whose page has an outstanding translation is not offered. The next eligible entry behind it is offered instead.
- R8: When `dn_ready` is low, the offered entry stays stored and `dn_valid` stays high in the next cycle.
- R9: While `MAX_OUT` translations are outstanding, `dn_valid` is 0.
- R10: `rsp_valid` with `rsp_vpn` releases that page's outstanding slot from the next cycle on. A response for a page that is not outstanding has no effect.
- R11: When `DEPTH` entries are stored, every `req_ready` is 0. Otherwise the lowest-index valid requester is the only one granted, and `req_ready[i]` is 1 exactly when no lower-index requester is valid.
- R12: After reset the queue and the table are empty, `dn_valid` is 0 and `req_ready[0]` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_no_merge | input | 1 | 1: never merge requests |
| req_valid | input | NREQ | Request valid per requester |
| req_vpn | input | NREQ*VPN_W | Virtual page per requester, requester i at bits [i*VPN_W +: VPN_W] |
| req_write | input | NREQ | Mode per requester, 1 = write |
| req_cnt | input | NREQ*CNT_W | Request count per requester |
| req_ready | output | NREQ | Acceptance per requester |
| dn_valid | output | 1 | Downstream lookup offered |
| dn_ready | input | 1 | Downstream accepts the offer |
| dn_vpn | output | VPN_W | Offered page |
| dn_write | output | 1 | Offered mode |
| dn_cnt | output | CNT_W | Number of requests the offer stands for |
| rsp_valid | input | 1 | Translation completed |
| rsp_vpn | input | VPN_W | Page of the completed translation |

## Verification
The first traffic stage repeats two pages with mixed modes against a stalled downstream. This separates merges from mode-split entries, drives counts into saturation and fills the queue, and a window change between same-page requests shows that merging is confined to one window. A stage with random acceptance and random responses over four pages exercises blocking behind in-flight pages, bypass by younger entries and the outstanding cap. A stage with merging turned off shows that every request is kept separately. A final mixed stage adds responses for pages that are not outstanding, which must be ignored.

// File: rtl/coal_pkg.sv
package coal_pkg;
    parameter int unsigned VPN_W = 8;
    parameter int unsigned CNT_W = 4;
    parameter int unsigned BKT_W = 3;

    typedef struct packed {
        logic [VPN_W-1:0] vpn;
        logic             wr;
        logic [CNT_W-1:0] cnt;
        logic [BKT_W-1:0] bkt;
    } entry_t;

    function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] a,
                                                 input logic [CNT_W-1:0] b);
        logic [CNT_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[CNT_W] ? {CNT_W{1'b1}} : s[CNT_W-1:0];
    endfunction
endpackage

// File: rtl/coal_arb.sv
module coal_arb #(
    parameter int NREQ = 2,
    localparam int IW = (NREQ > 1) ? $clog2(NREQ) : 1
) (
    input  logic [NREQ-1:0] valid,
    input  logic            full,
    output logic [NREQ-1:0] ready,
    output logic            gnt_vld,
    output logic [IW-1:0]   gnt_idx
);
    always_comb begin
        ready   = '0;
        gnt_vld = 1'b0;
        gnt_idx = '0;
        for (int i = 0; i < NREQ; i++) begin
            if (!full && !gnt_vld) begin
                ready[i] = 1'b1;
                if (valid[i]) begin
                    gnt_vld = 1'b1;
                    gnt_idx = IW'(i);
                end
            end
        end
    end
endmodule

// File: rtl/coal_itable.sv
module coal_itable
    import coal_pkg::*;
#(
    parameter int MAX_OUT = 2,
    localparam int SW = (MAX_OUT > 1) ? $clog2(MAX_OUT) : 1
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            alloc,
    input  logic [VPN_W-1:0]                alloc_vpn,
    input  logic                            release_vld,
    input  logic [VPN_W-1:0]                release_vpn,
    output logic [MAX_OUT-1:0]              slot_vld,
    output logic [MAX_OUT-1:0][VPN_W-1:0]   slot_vpn,
    output logic                            tbl_full
);
    logic          have_free;
    logic [SW-1:0] free_idx;

    always_comb begin
        have_free = 1'b0;
        free_idx  = '0;
        for (int j = 0; j < MAX_OUT; j++) begin
            if (!slot_vld[j] && !have_free) begin
                have_free = 1'b1;
                free_idx  = SW'(j);
            end
        end
    end

    assign tbl_full = &slot_vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_vld <= '0;
            slot_vpn <= '0;
        end else begin
            for (int j = 0; j < MAX_OUT; j++) begin
                if (release_vld && slot_vld[j] && slot_vpn[j] == release_vpn)
                    slot_vld[j] <= 1'b0;
            end
            if (alloc && have_free) begin
                slot_vld[free_idx] <= 1'b1;
                slot_vpn[free_idx] <= alloc_vpn;
            end
        end
    end
endmodule

// File: rtl/coal_store.sv
module coal_store
    import coal_pkg::*;
#(
    parameter int DEPTH   = 4,
    parameter int MAX_OUT = 2,
    parameter int WIN     = 4,
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int WW = (WIN > 1) ? $clog2(WIN) : 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cfg_no_merge,
    input  logic                          in_vld,
    input  logic [VPN_W-1:0]              in_vpn,
    input  logic                          in_wr,
    input  logic [CNT_W-1:0]              in_cnt,
    input  logic [MAX_OUT-1:0]            slot_vld,
    input  logic [MAX_OUT-1:0][VPN_W-1:0] slot_vpn,
    input  logic                          tbl_full,
    input  logic                          dn_ready,
    output logic                          full,
    output logic [CW-1:0]                 occ,
    output logic                          dn_valid,
    output logic [VPN_W-1:0]              dn_vpn,
    output logic                          dn_write,
    output logic [CNT_W-1:0]              dn_cnt,
    output logic                          fire
);
    entry_t           ent [DEPTH];
    entry_t           nxt [DEPTH];
    logic [CW-1:0]    nocc;
    logic [WW-1:0]    wcnt;
    logic [BKT_W-1:0] bkt;
    logic [DEPTH-1:0] hit;
    logic             sel_vld;
    logic [IW-1:0]    sel_idx;
    logic             m_vld;
    logic [IW-1:0]    m_idx;
    entry_t           fresh;

    assign full = (occ == CW'(DEPTH));

    // page-in-flight lookup against every slot of the issued table
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            hit[i] = 1'b0;
            for (int j = 0; j < MAX_OUT; j++)
                if (slot_vld[j] && slot_vpn[j] == ent[i].vpn) hit[i] = 1'b1;
        end
    end

    // oldest eligible entry
    always_comb begin
        sel_vld = 1'b0;
        sel_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!sel_vld && i < int'(occ) && !hit[i]) begin
                sel_vld = 1'b1;
                sel_idx = IW'(i);
            end
        end
    end

    assign dn_valid = sel_vld && !tbl_full;
    assign dn_vpn   = ent[sel_idx].vpn;
    assign dn_write = ent[sel_idx].wr;
    assign dn_cnt   = ent[sel_idx].cnt;
    assign fire     = dn_valid && dn_ready;

    // merge target: same page, mode and window, not the one leaving now
    always_comb begin
        m_vld = 1'b0;
        m_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (in_vld && !cfg_no_merge && !m_vld && i < int'(occ)
                && !(fire && i == int'(sel_idx))
                && ent[i].vpn == in_vpn && ent[i].wr == in_wr && ent[i].bkt == bkt) begin
                m_vld = 1'b1;
                m_idx = IW'(i);
            end
        end
    end

    always_comb begin
        fresh.vpn = in_vpn;
        fresh.wr  = in_wr;
        fresh.cnt = in_cnt;
        fresh.bkt = bkt;
        nocc = occ - CW'(fire);
        for (int i = 0; i < DEPTH; i++) begin
            int src;
            src = i + ((fire && i >= int'(sel_idx)) ? 1 : 0);
            nxt[i] = '0;
            if (src < DEPTH) begin
                nxt[i] = ent[src];
                if (m_vld && src == int'(m_idx))
                    nxt[i].cnt = sat_add(ent[src].cnt, in_cnt);
            end
            if (in_vld && !m_vld && i == int'(nocc)) nxt[i] = fresh;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            occ  <= '0;
            wcnt <= '0;
            bkt  <= '0;
            for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
        end else begin
            occ <= nocc + CW'(in_vld && !m_vld);
            for (int i = 0; i < DEPTH; i++) ent[i] <= nxt[i];
            if (wcnt == WW'(WIN - 1)) begin
                wcnt <= '0;
                bkt  <= bkt + 1'b1;
            end else begin
                wcnt <= wcnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/coal_top.sv
module coal_top
    import coal_pkg::*;
#(
    parameter int NREQ    = 2,
    parameter int DEPTH   = 4,
    parameter int MAX_OUT = 2,
    parameter int WIN     = 4,
    localparam int IW = (NREQ > 1) ? $clog2(NREQ) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cfg_no_merge,
    input  logic [NREQ-1:0]        req_valid,
    input  logic [NREQ*VPN_W-1:0]  req_vpn,
    input  logic [NREQ-1:0]        req_write,
    input  logic [NREQ*CNT_W-1:0]  req_cnt,
    output logic [NREQ-1:0]        req_ready,
    output logic                   dn_valid,
    input  logic                   dn_ready,
    output logic [VPN_W-1:0]       dn_vpn,
    output logic                   dn_write,
    output logic [CNT_W-1:0]       dn_cnt,
    input  logic                   rsp_valid,
    input  logic [VPN_W-1:0]       rsp_vpn
);
    logic                          full;
    logic                          gnt_vld;
    logic [IW-1:0]                 gnt_idx;
    logic [CW-1:0]                 occ;
    logic                          fire;
    logic                          tbl_full;
    logic [MAX_OUT-1:0]            slot_vld;
    logic [MAX_OUT-1:0][VPN_W-1:0] slot_vpn;

    coal_arb #(.NREQ(NREQ)) u_arb (
        .valid(req_valid), .full(full), .ready(req_ready),
        .gnt_vld(gnt_vld), .gnt_idx(gnt_idx)
    );

    coal_store #(.DEPTH(DEPTH), .MAX_OUT(MAX_OUT), .WIN(WIN)) u_store (
        .clk(clk), .rst(rst), .cfg_no_merge(cfg_no_merge),
        .in_vld(gnt_vld),
        .in_vpn(req_vpn[gnt_idx*VPN_W +: VPN_W]),
        .in_wr(req_write[gnt_idx]),
        .in_cnt(req_cnt[gnt_idx*CNT_W +: CNT_W]),
        .slot_vld(slot_vld), .slot_vpn(slot_vpn), .tbl_full(tbl_full),
        .dn_ready(dn_ready), .full(full), .occ(occ),
        .dn_valid(dn_valid), .dn_vpn(dn_vpn), .dn_write(dn_write),
        .dn_cnt(dn_cnt), .fire(fire)
    );

    coal_itable #(.MAX_OUT(MAX_OUT)) u_itable (
        .clk(clk), .rst(rst), .alloc(fire), .alloc_vpn(dn_vpn),
        .release_vld(rsp_valid), .release_vpn(rsp_vpn),
        .slot_vld(slot_vld), .slot_vpn(slot_vpn), .tbl_full(tbl_full)
    );
endmodule

// File: rtl/coal_chk.sv
module coal_chk
    import coal_pkg::*;
#(
    parameter int NREQ    = 2,
    parameter int DEPTH   = 4,
    parameter int MAX_OUT = 2,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic                          clk,
    input logic                          rst,
    input logic [NREQ-1:0]               req_valid,
    input logic [NREQ-1:0]               req_ready,
    input logic                          dn_valid,
    input logic                          dn_ready,
    input logic [VPN_W-1:0]              dn_vpn,
    input logic [MAX_OUT-1:0]            slot_vld,
    input logic [MAX_OUT-1:0][VPN_W-1:0] slot_vpn,
    input logic [CW-1:0]                 occ
);
    logic dup;
    always_comb begin
        dup = 1'b0;
        for (int j = 0; j < MAX_OUT; j++)
            if (slot_vld[j] && slot_vpn[j] == dn_vpn) dup = 1'b1;
    end

    p_no_dup_page_r7: assert property (@(posedge clk) disable iff (rst)
        dn_valid |-> !dup);
    p_cap_r9: assert property (@(posedge clk) disable iff (rst)
        ($countones(slot_vld) == MAX_OUT) |-> !dn_valid);
    p_hold_offer_r8: assert property (@(posedge clk) disable iff (rst)
        (dn_valid && !dn_ready) |=> dn_valid);
    p_full_stall_r11: assert property (@(posedge clk) disable iff (rst)
        (occ == CW'(DEPTH)) |-> (req_ready == '0));
    p_one_grant_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(req_valid & req_ready));
    p_reset_empty_r12: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (occ == '0 && !dn_valid && slot_vld == '0));
endmodule

bind coal_top coal_chk #(.NREQ(NREQ), .DEPTH(DEPTH), .MAX_OUT(MAX_OUT)) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_vpn(dn_vpn),
    .slot_vld(slot_vld), .slot_vpn(slot_vpn), .occ(occ)
);

// File: tb/sim_coal_top.sv
module sim_coal_top;
    localparam int NREQ = 2, DEPTH = 4, MAX_OUT = 2, WIN = 4;
    localparam int VW = 8, CWID = 4, NBKT = 8, NCYC = 400;

    logic clk = 1'b0, rst = 1'b1, cfg_no_merge = 1'b0;
    logic [NREQ-1:0]      req_valid = '0, req_write = '0;
    logic [NREQ*VW-1:0]   req_vpn = '0;
    logic [NREQ*CWID-1:0] req_cnt = '0;
    logic [NREQ-1:0]      req_ready;
    logic dn_valid, dn_ready = 1'b0, dn_write, rsp_valid = 1'b0;
    logic [VW-1:0]   dn_vpn, rsp_vpn = '0;
    logic [CWID-1:0] dn_cnt;

    always #4 clk = ~clk;

    coal_top #(.NREQ(NREQ), .DEPTH(DEPTH), .MAX_OUT(MAX_OUT), .WIN(WIN)) u0 (
        .clk(clk), .rst(rst), .cfg_no_merge(cfg_no_merge),
        .req_valid(req_valid), .req_vpn(req_vpn), .req_write(req_write),
        .req_cnt(req_cnt), .req_ready(req_ready), .dn_valid(dn_valid),
        .dn_ready(dn_ready), .dn_vpn(dn_vpn), .dn_write(dn_write),
        .dn_cnt(dn_cnt), .rsp_valid(rsp_valid), .rsp_vpn(rsp_vpn)
    );

    typedef struct { int vpn; int wr; int cnt; int bkt; } m_t;
    m_t q[$];
    int outq[$];
    int wcnt = 0, bkt = 0;
    int checks = 0, errors = 0;
    bit done = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d time=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit in_flight(input int v);
        foreach (outq[j]) if (outq[j] == v) return 1;
        return 0;
    endfunction

    initial begin
        #80000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R12: empty after reset
        chk("R12 dn_valid", dn_valid, 0);
        chk("R12 req_ready0", req_ready[0], 1);
        for (int cyc = 0; cyc < NCYC; cyc++) begin
            int gnt, k, vmax, pos;
            bit seen, full, ev, fire, merged;
            if (cyc > 0) @(negedge clk);
            vmax = (cyc < 60) ? 2 : (cyc < 220 ? 3 : 5);
            cfg_no_merge = (cyc >= 160 && cyc < 220);
            dn_ready = (cyc < 30) ? 1'b0 : ($urandom_range(0, 2) != 0);
            for (int p = 0; p < NREQ; p++) begin
                req_valid[p] = ($urandom_range(0, 3) != 0);
                req_vpn[p*VW +: VW] = VW'(cyc < 60 ? $urandom_range(1, 2) : $urandom_range(0, vmax));
                req_write[p] = $urandom_range(0, 1);
                req_cnt[p*CWID +: CWID] = CWID'($urandom_range(1, 7));
            end
            rsp_valid = 1'b0;
            if (cyc >= 30 && $urandom_range(0, 2) == 0) begin
                rsp_valid = 1'b1;
                if (outq.size() > 0 && $urandom_range(0, 3) != 0)
                    rsp_vpn = VW'(outq[$urandom_range(0, outq.size() - 1)]);
                else
                    rsp_vpn = VW'($urandom_range(0, 7)); // R10: may be a page not in flight
            end
            #1;
            // reference expectations
            full = (q.size() == DEPTH);
            seen = 0; gnt = -1;
            for (int p = 0; p < NREQ; p++) begin
                chk("R11 req_ready", req_ready[p], (!full && !seen) ? 1 : 0);
                if (req_valid[p]) begin
                    if (!full && !seen) gnt = p;
                    seen = 1;
                end
            end
            k = -1;
            foreach (q[i]) if (k < 0 && !in_flight(q[i].vpn)) k = i;
            ev = (k >= 0) && (outq.size() < MAX_OUT);
            chk("R6 R7 R8 R9 R10 dn_valid", dn_valid, ev);
            if (ev) begin
                chk("R2 R3 R4 R6 R7 dn_vpn", dn_vpn, q[k].vpn);
                chk("R2 R6 dn_write", dn_write, q[k].wr);
                chk("R1 R5 dn_cnt", dn_cnt, q[k].cnt);
            end
            // state update for the coming edge
            fire = ev && dn_ready;
            if (rsp_valid) begin
                pos = -1;
                foreach (outq[j]) if (outq[j] == int'(rsp_vpn)) pos = j;
                if (pos >= 0) outq.delete(pos);
            end
            if (fire) begin
                outq.push_back(q[k].vpn);
                q.delete(k);
            end
            if (gnt >= 0) begin
                m_t n;
                n.vpn = int'(req_vpn[gnt*VW +: VW]);
                n.wr  = int'(req_write[gnt]);
                n.cnt = int'(req_cnt[gnt*CWID +: CWID]);
                n.bkt = bkt;
                merged = 0;
                if (!cfg_no_merge) begin
                    foreach (q[i]) begin
                        if (!merged && q[i].vpn == n.vpn && q[i].wr == n.wr && q[i].bkt == bkt) begin
                            q[i].cnt = (q[i].cnt + n.cnt > 15) ? 15 : q[i].cnt + n.cnt;
                            merged = 1;
                        end
                    end
                end
                if (!merged) q.push_back(n);
            end
            if (wcnt == WIN - 1) begin
                wcnt = 0;
                bkt = (bkt + 1) % NBKT;
            end else begin
                wcnt++;
            end
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule